// File: doc/BRIEF.md
# Multi-Bus Counting Register

This block is a 16-bit working register for a processor datapath. On the rising edge of the master clock it can take a word from the shared data bus, count up by one or count down by one. It can also hold its value. Its stored word can be placed onto any of three shared buses through three output drivers: the data bus, the address bus and the lamps bus that feeds the console display. Each driver has its own enable, and each releases its bus to high impedance when that enable is off.

Every control input is active low. A priority order settles the case where several controls are asserted at once, so the register does one thing per clock and never needs an arbiter outside it. All three buses are bidirectional nets because other units drive them too. The register reads only the data bus. On the address and lamps buses it only drives or releases.

Top module: `bus_count_reg`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the stored word becomes 0x0000, whatever the other controls are.
- R2: When `load_n` is low at a rising edge (reset inactive), the stored word becomes the value on `dbus` at that edge.
- R3: When `inc_n` is low and neither reset nor load is active, the stored word goes up by one at the edge, and 0xFFFF becomes 0x0000.
- R4: When `dec_n` is low and no reset, load or increment is active, the stored word goes down by one at the edge, and 0x0000 becomes 0xFFFF.
- R5: Precedence is fixed as reset, then load, then increment, then decrement. A lower-ranked control asserted together with a higher one has no effect on the stored word.
- R6: With reset, load, increment and decrement all high, the stored word keeps its value across clock edges.
- R7: While `den_n` is low, `dbus` carries the stored word. While it is high, the block releases `dbus` (high impedance), so a value driven by another unit reads back unchanged.
- R8: While `aen_n` is low, `abus` carries the stored word. While it is high, `abus` is released.
- R9: While `len_n` is low, `lbus` carries the stored word. While it is high, `lbus` is released.
- R10: The three output enables act independently of each other and never change the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Capture data bus, active low |
| inc_n | input | 1 | Count up, active low |
| dec_n | input | 1 | Count down, active low |
| den_n | input | 1 | Drive data bus, active low |
| aen_n | input | 1 | Drive address bus, active low |
| len_n | input | 1 | Drive lamps bus, active low |
| dbus | inout | 16 | Shared data bus |
| abus | inout | 16 | Shared address bus |
| lbus | inout | 16 | Shared lamps bus |

## Verification
Increment and decrement can be asserted in the same cycle. The bench pulls both low at 0x0000 and at 0xFFFF, where the two results differ most, and then looks on the lamps bus for the incremented value alone. Load can also coincide with the data-bus drive, so the register reloads its own output. The bench provokes this with `load_n` and `den_n` both low and the bench-side data driver off, and it judges the case by seeing the word unchanged after the edge. It also combines load with increment and decrement to show that the captured bus value wins.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    // Operation chosen for the coming clock edge, already priority-resolved.
    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_CLR  = 3'd1,
        OP_LOAD = 3'd2,
        OP_UP   = 3'd3,
        OP_DOWN = 3'd4
    } bcr_op_e;

    // Number of shared buses the register can drive.
    localparam int unsigned BCR_NUM_BUSES = 3;

endpackage

// File: rtl/bcr_op_sel.sv
module bcr_op_sel
    import bcr_pkg::*;
(
    input  logic    rst_n,
    input  logic    load_n,
    input  logic    inc_n,
    input  logic    dec_n,
    output bcr_op_e op
);

    // Active-high view of the strobes.
    logic do_clr;
    logic do_load;
    logic do_up;
    logic do_down;

    always_comb begin
        do_clr  = ~rst_n;
        do_load = ~load_n;
        do_up   = ~inc_n;
        do_down = ~dec_n;
    end

    // Fixed precedence: clear, load, up, down.
    always_comb begin
        if (do_clr) begin
            op = OP_CLR;
        end else if (do_load) begin
            op = OP_LOAD;
        end else if (do_up) begin
            op = OP_UP;
        end else if (do_down) begin
            op = OP_DOWN;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/bcr_next_val.sv
module bcr_next_val
    import bcr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  bcr_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);

    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    // One shared adder: +1 or +(-1), modular in W bits.
    logic [W-1:0] step;
    logic [W-1:0] sum;

    always_comb begin
        step = (op == OP_DOWN) ? ALL1 : ONE;
        sum  = cur + step;
    end

    always_comb begin
        unique case (op)
            OP_CLR:  nxt = '0;
            OP_LOAD: nxt = din;
            OP_UP:   nxt = sum;
            OP_DOWN: nxt = sum;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/bus_count_reg.sv
module bus_count_reg
    import bcr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_n,
    input  logic          inc_n,
    input  logic          dec_n,
    input  logic          den_n,
    input  logic          aen_n,
    input  logic          len_n,
    inout  wire  [W-1:0]  dbus,
    inout  wire  [W-1:0]  abus,
    inout  wire  [W-1:0]  lbus
);

    typedef struct packed {
        logic [W-1:0] val;
    } state_t;

    state_t  state_d;
    state_t  state_q;
    bcr_op_e op;
    logic [W-1:0] nxt_val;

    bcr_op_sel u_op_sel (
        .rst_n  (rst_n),
        .load_n (load_n),
        .inc_n  (inc_n),
        .dec_n  (dec_n),
        .op     (op)
    );

    bcr_next_val #(.W(W)) u_next (
        .op  (op),
        .cur (state_q.val),
        .din (dbus),
        .nxt (nxt_val)
    );

    always_comb begin
        state_d     = state_q;
        state_d.val = nxt_val;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Output drivers: each releases its bus when its enable is high.
    logic [BCR_NUM_BUSES-1:0] drv_en;

    always_comb begin
        drv_en[0] = ~den_n;
        drv_en[1] = ~aen_n;
        drv_en[2] = ~len_n;
    end

    assign dbus = drv_en[0] ? state_q.val : {W{1'bz}};
    assign abus = drv_en[1] ? state_q.val : {W{1'bz}};
    assign lbus = drv_en[2] ? state_q.val : {W{1'bz}};

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
    parameter int unsigned W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_n,
    input logic          inc_n,
    input logic          dec_n,
    input logic          den_n,
    input logic          aen_n,
    input logic          len_n,
    input logic [W-1:0]  dbus,
    input logic [W-1:0]  abus,
    input logic [W-1:0]  lbus,
    input logic [W-1:0]  val
);

    // R1: clear
    assert_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (val == '0));

    // R2 / R5: load wins over counting
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (val == $past(dbus)));

    // R3 / R5: increment wins over decrement
    assert_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !inc_n) |=> (val == $past(val) + 1'b1));

    // R4
    assert_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && inc_n && !dec_n) |=> (val == $past(val) - 1'b1));

    // R6
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && inc_n && dec_n) |=> $stable(val));

    // R8
    assert_abus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !aen_n |-> (abus == val));

    // R9
    assert_lbus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !len_n |-> (lbus == val));

    // R7
    assert_dbus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && load_n) |-> (dbus == val));

endmodule

bind bus_count_reg bcr_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .inc_n  (inc_n),
    .dec_n  (dec_n),
    .den_n  (den_n),
    .aen_n  (aen_n),
    .len_n  (len_n),
    .dbus   (dbus),
    .abus   (abus),
    .lbus   (lbus),
    .val    (state_q.val)
);

// File: tb/bus_count_reg_tb.sv
module bus_count_reg_tb;

    localparam int W = 16;
    localparam logic [W-1:0] PROBE = 16'h5A3C;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, load_n, inc_n, dec_n, den_n, aen_n, len_n;
    logic [W-1:0] tb_d, tb_a, tb_l;
    logic tb_d_on, tb_a_on, tb_l_on;

    wire [W-1:0] dbus;
    wire [W-1:0] abus;
    wire [W-1:0] lbus;

    assign dbus = tb_d_on ? tb_d : {W{1'bz}};
    assign abus = tb_a_on ? tb_a : {W{1'bz}};
    assign lbus = tb_l_on ? tb_l : {W{1'bz}};

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bus_count_reg #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .inc_n(inc_n), .dec_n(dec_n),
        .den_n(den_n), .aen_n(aen_n), .len_n(len_n),
        .dbus(dbus), .abus(abus), .lbus(lbus)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rst_n = 1; load_n = 1; inc_n = 1; dec_n = 1;
        den_n = 1; aen_n = 1; len_n = 1;
        tb_d_on = 0; tb_a_on = 0; tb_l_on = 0;
        tb_d = '0; tb_a = '0; tb_l = '0;
    endtask

    // Inputs are set at a falling edge; this passes one rising edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read the stored word through the lamps bus, at a falling edge.
    task automatic peek(output logic [W-1:0] v);
        len_n = 0;
        tb_l_on = 0;
        #1;
        v = lbus;
        len_n = 1;
    endtask

    task automatic load_word(input logic [W-1:0] w);
        idle();
        tb_d = w; tb_d_on = 1; load_n = 0;
        tick();
        idle();
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        load_word(16'hBEEF);
        rst_n = 0; load_n = 0; inc_n = 0; dec_n = 0; tb_d = 16'h1234; tb_d_on = 1;
        tick();
        idle();
        peek(v);
        check("R1 clear beats all", v, 16'h0000);
    endtask

    task automatic t_load();
        logic [W-1:0] v;
        load_word(16'hC0DE);
        peek(v);
        check("R2 load C0DE", v, 16'hC0DE);
        load_word(16'h0001);
        peek(v);
        check("R2 load 0001", v, 16'h0001);
    endtask

    task automatic t_inc();
        logic [W-1:0] v;
        load_word(16'h00FF);
        inc_n = 0; tick(); idle();
        peek(v);
        check("R3 inc 00FF", v, 16'h0100);
        load_word(16'hFFFF);
        inc_n = 0; tick(); idle();
        peek(v);
        check("R3 inc wrap", v, 16'h0000);
    endtask

    task automatic t_dec();
        logic [W-1:0] v;
        load_word(16'h0100);
        dec_n = 0; tick(); tick(); idle();
        peek(v);
        check("R4 dec twice", v, 16'h00FE);
        load_word(16'h0000);
        dec_n = 0; tick(); idle();
        peek(v);
        check("R4 dec wrap", v, 16'hFFFF);
    endtask

    task automatic t_priority();
        logic [W-1:0] v;
        load_word(16'h0000);
        inc_n = 0; dec_n = 0; tick(); idle();
        peek(v);
        check("R5 inc over dec at 0000", v, 16'h0001);
        load_word(16'hFFFF);
        inc_n = 0; dec_n = 0; tick(); idle();
        peek(v);
        check("R5 inc over dec at FFFF", v, 16'h0000);
        load_word(16'h1000);
        tb_d = 16'h7777; tb_d_on = 1; load_n = 0; inc_n = 0; dec_n = 0;
        tick(); idle();
        peek(v);
        check("R5 load over counting", v, 16'h7777);
        // Load while the register itself drives the data bus: word unchanged.
        load_word(16'h4321);
        load_n = 0; den_n = 0; inc_n = 0;
        tick(); idle();
        peek(v);
        check("R5 load own output", v, 16'h4321);
    endtask

    task automatic t_hold();
        logic [W-1:0] v;
        load_word(16'hA55A);
        tb_d = 16'h0F0F; tb_d_on = 1;
        tick(); tick(); tick();
        idle();
        peek(v);
        check("R6 hold", v, 16'hA55A);
    endtask

    task automatic t_buses();
        logic [W-1:0] v;
        load_word(16'h9876);
        // All enabled at once.
        den_n = 0; aen_n = 0; len_n = 0;
        #1;
        check("R7 dbus driven", dbus, 16'h9876);
        check("R8 abus driven", abus, 16'h9876);
        check("R9 lbus driven", lbus, 16'h9876);
        tick();
        idle();
        // All released: bench probe values read back untouched.
        tb_d = PROBE; tb_d_on = 1; tb_a = ~PROBE; tb_a_on = 1; tb_l = PROBE ^ 16'hFFF0; tb_l_on = 1;
        #1;
        check("R7 dbus released", dbus, PROBE);
        check("R8 abus released", abus, ~PROBE);
        check("R9 lbus released", lbus, PROBE ^ 16'hFFF0);
        idle();
        @(negedge clk);
        // Address only: data and lamps stay released.
        aen_n = 0; tb_d = PROBE; tb_d_on = 1; tb_l = ~PROBE; tb_l_on = 1;
        #1;
        check("R10 abus alone", abus, 16'h9876);
        check("R10 dbus untouched", dbus, PROBE);
        check("R10 lbus untouched", lbus, ~PROBE);
        tb_d_on = 0;
        @(negedge clk);
        idle();
        peek(v);
        check("R10 enables keep word", v, 16'h9876);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] v;
        idle();
        rst_n = 0;
        tick();
        tick();
        idle();
        peek(v);
        check("R1 reset state", v, 16'h0000);
        t_reset();
        t_load();
        t_inc();
        t_dec();
        t_priority();
        t_hold();
        t_buses();
        done = 1;
        finish_run();
    end

endmodule